// File: doc/BRIEF.md
# Two-Wire Bus Master Register Interface

This block is the software-visible register file of a two-wire serial bus master. A CPU writes and reads it over a simple 32-bit bus (write strobe, address, write data; read data follows the address combinationally). The block holds the settings a transfer needs: target register address, data word, command code, hardware and runtime device addresses, bus clock divider and SDA output delay. It drives them to a separate serial engine that is not part of this block. It starts that engine with a level that stays high for the whole transfer and ends the transfer when the engine returns a one-cycle completion pulse with its error flags.

Software starts a transfer, aborts one, or resets the whole block through self-clearing control bits. Results land in a status register whose event bits are cleared by writing 1, and a single interrupt line follows the enabled event bits. A line-control register lets software take manual control of the SDA and SCL pins and read back their live levels. A device-mode register launches the bus-wide init sequence and reports when that sequence has finished.

Top module: `twb_regif`

## Requirements
- R1: After reset every register reads 0, except that line-control bits 4 and 5 read the live `line_sda_in` and `line_scl_in`. `irq`, `eng_go`, `eng_abort` and `dm_go` are 0.
- R2: Configuration registers read back as written, within their fields. Offset 0x04 has the divider in 7:0 and the SDA delay in 10:8. Offset 0x10 holds an 8-bit register address. Offset 0x1C holds 32 data bits. Offset 0x30 has the hardware address in 15:0 and the runtime address in 23:16. Offset 0x2C holds an 8-bit command. Bits outside these fields read 0, and each field appears on its engine output.
- R3: Writing control (0x00) with bit 7 set while idle raises `eng_go` after that write's clock edge. Control bit 7 then reads 1 until the transfer ends.
- R4: A completion pulse (`eng_done`) with no error flags, during a transfer, clears bit 7 and `eng_go` at the next edge and sets status (0x0C) bit 0. If `eng_rd_vld` is also high, the data register takes `eng_rdata`.
- R5: A completion pulse with `eng_ack_err` or a nonzero `eng_data_err` sets status bit 1 instead of bit 0. The same edge copies `eng_data_err` into status bits 11:8 and `eng_ack_err` into status bit 16.
- R6: Writing the command register, or writing control with bit 7, while a transfer runs sets status bit 2 (load-busy). The command register keeps its old value.
- R7: Writing control with bit 6 during a transfer ends it at that edge. `eng_abort` is high for exactly the following cycle. Status bit 1 is set, and bits 16 and 11:8 stay 0.
- R8: Status bits 0, 1 and 2 clear when written with 1, and a 0 leaves them alone. Clearing bit 1 also clears bits 11:8 and 16.
- R9: `irq` equals control bit 1 ANDed with the OR over bits 0 to 2 of (status AND interrupt enable at 0x08).
- R10: Line-control (0x24) bits 0 to 3 drive `line_sda_oe`, `line_sda_val`, `line_scl_oe` and `line_scl_val`. Bits 4 and 5 read the pin inputs, and writes to them have no effect.
- R11: Writing device-mode (0x28) with bit 31 set raises `dm_go`. Bit 31 reads 1 until `dm_done` pulses. The mode-data, mode-register and device-address bytes at 23:16, 15:8 and 7:0 drive `dm_data`, `dm_reg` and `dm_dev`. Writes while bit 31 is set are ignored.
- R12: Writing control bit 0 makes it read 1 for SRST_CYC cycles. During that time every register returns to its reset value and bus writes are ignored.
- R13: A completion pulse while no transfer runs changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | CPU write strobe |
| bus_addr | input | ADDR_W | CPU byte address |
| bus_wdata | input | 32 | CPU write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| eng_go | output | 1 | Transfer in progress; engine runs while high |
| eng_abort | output | 1 | One-cycle abort pulse to the engine |
| eng_cmd | output | 8 | Command code |
| eng_reg_addr | output | 8 | Target register address |
| eng_wdata | output | 32 | Data register contents |
| eng_hw_addr | output | 16 | Hardware device address |
| eng_rt_addr | output | 8 | Runtime device address |
| eng_clk_div | output | 8 | Bus clock divider |
| eng_sda_dly | output | 3 | SDA output delay |
| eng_done | input | 1 | Transfer completion pulse |
| eng_ack_err | input | 1 | Missing acknowledge, valid with `eng_done` |
| eng_data_err | input | 4 | Per-byte parity error flags, valid with `eng_done` |
| eng_rd_vld | input | 1 | `eng_rdata` valid with `eng_done` |
| eng_rdata | input | 32 | Read result from the engine |
| line_sda_oe | output | 1 | Manual SDA override enable |
| line_sda_val | output | 1 | Manual SDA value |
| line_scl_oe | output | 1 | Manual SCL override enable |
| line_scl_val | output | 1 | Manual SCL value |
| line_sda_in | input | 1 | Live SDA level |
| line_scl_in | input | 1 | Live SCL level |
| dm_go | output | 1 | Device-mode init sequence requested |
| dm_data | output | 8 | Mode-data byte |
| dm_reg | output | 8 | Mode-register byte |
| dm_dev | output | 8 | Device address for the init sequence |
| dm_done | input | 1 | Init sequence finished pulse |

## Verification
The bench builds the block with SRST_CYC set to 3. At that setting the soft-reset window can be watched one cycle at a time: it must read 1 for exactly three cycles and then 0, and a write made inside the window must be lost. The other parameters stay at their defaults. This keeps the 4-bit data-error field and the 3-bit enable small enough to sweep every error combination, every enable/global-enable pair and every line-control and pin pattern in full.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_CLK   = 8'h04;
  localparam logic [7:0] OFS_IEN   = 8'h08;
  localparam logic [7:0] OFS_IST   = 8'h0C;
  localparam logic [7:0] OFS_ADR   = 8'h10;
  localparam logic [7:0] OFS_DAT   = 8'h1C;
  localparam logic [7:0] OFS_LINE  = 8'h24;
  localparam logic [7:0] OFS_DMODE = 8'h28;
  localparam logic [7:0] OFS_CMD   = 8'h2C;
  localparam logic [7:0] OFS_DEV   = 8'h30;

  // control bits
  localparam int CB_START = 7;
  localparam int CB_ABORT = 6;
  localparam int CB_GIE   = 1;
  localparam int CB_SRST  = 0;

  // status bits
  localparam int SB_OVER    = 0;
  localparam int SB_ERR     = 1;
  localparam int SB_LBSY    = 2;
  localparam int SB_DERR_LO = 8;
  localparam int SB_ACK     = 16;

  // field positions in other registers
  localparam int CK_DLY_LO  = 8;
  localparam int DEV_RT_LO  = 16;
  localparam int DM_GO      = 31;
  localparam int DM_DATA_LO = 16;
  localparam int DM_REG_LO  = 8;
  localparam int LN_SDA_IN  = 4;
  localparam int LN_SCL_IN  = 5;

  typedef struct packed {
    logic ctrl;
    logic clk;
    logic ien;
    logic ist;
    logic adr;
    logic dat;
    logic line;
    logic dmode;
    logic cmd;
    logic dev;
  } twb_wsel_t;
endpackage

// File: rtl/twb_xfer_ctrl.sv
module twb_xfer_ctrl
  import twb_pkg::*;
#(
  parameter int SRST_CYC = 4,
  parameter int DERR_W   = 4,
  parameter int SRC_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_ctrl,
  input  logic              we_ien,
  input  logic              we_ist,
  input  logic              we_cmd,
  input  logic [7:0]        wd,
  input  logic              eng_done,
  input  logic              eng_ack_err,
  input  logic [DERR_W-1:0] eng_data_err,
  output logic              busy_o,
  output logic              abort_o,
  output logic              srst_o,
  output logic              done_acc_o,
  output logic              cmd_load_o,
  output logic              irq_o,
  output logic [31:0]       ctrl_rd_o,
  output logic [31:0]       ien_rd_o,
  output logic [31:0]       ist_rd_o
);
  localparam int CNT_W = $clog2(SRST_CYC + 1);

  logic [CNT_W-1:0]  sr_cnt;
  logic              busy_q, gie_q, abort_q;
  logic              st_over, st_err, st_lb, st_ack;
  logic [DERR_W-1:0] st_derr;
  logic [SRC_W-1:0]  ien_q;
  logic              sr_req, start_req, abort_req, fail_in, sr_idle;
  logic              unused_mid;

  assign unused_mid = ^wd[5:3];
  assign sr_idle    = (sr_cnt == '0);
  assign sr_req     = we_ctrl && wd[CB_SRST];
  assign abort_req  = we_ctrl && wd[CB_ABORT] && !sr_req;
  assign start_req  = we_ctrl && wd[CB_START] && !wd[CB_ABORT] && !sr_req;
  assign fail_in    = eng_ack_err || (|eng_data_err);
  assign done_acc_o = busy_q && eng_done && !abort_req && !sr_req && sr_idle;
  assign cmd_load_o = we_cmd && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_cnt <= '0; busy_q <= 1'b0; gie_q <= 1'b0; abort_q <= 1'b0;
      st_over <= 1'b0; st_err <= 1'b0; st_lb <= 1'b0; st_ack <= 1'b0;
      st_derr <= '0; ien_q <= '0;
    end else if (!sr_idle || sr_req) begin
      sr_cnt  <= sr_idle ? CNT_W'(SRST_CYC) : sr_cnt - 1'b1;
      busy_q <= 1'b0; gie_q <= 1'b0; abort_q <= 1'b0;
      st_over <= 1'b0; st_err <= 1'b0; st_lb <= 1'b0; st_ack <= 1'b0;
      st_derr <= '0; ien_q <= '0;
    end else begin
      abort_q <= 1'b0;
      if (we_ctrl) gie_q <= wd[CB_GIE];
      if (we_ien)  ien_q <= wd[SRC_W-1:0];
      if (we_ist) begin
        if (wd[SB_OVER]) st_over <= 1'b0;
        if (wd[SB_LBSY]) st_lb   <= 1'b0;
        if (wd[SB_ERR]) begin
          st_err <= 1'b0; st_ack <= 1'b0; st_derr <= '0;
        end
      end
      if (busy_q && abort_req) begin
        busy_q  <= 1'b0;
        abort_q <= 1'b1;
        st_err  <= 1'b1;
      end else if (done_acc_o) begin
        busy_q <= 1'b0;
        if (fail_in) begin
          st_err  <= 1'b1;
          st_ack  <= eng_ack_err;
          st_derr <= eng_data_err;
        end else begin
          st_over <= 1'b1;
        end
      end else if (!busy_q && start_req) begin
        busy_q <= 1'b1;
      end
      if (busy_q && (we_cmd || start_req)) st_lb <= 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign abort_o = abort_q;
  assign srst_o  = !sr_idle;
  assign irq_o   = gie_q && |(ien_q & {st_lb, st_err, st_over});

  always_comb begin
    ctrl_rd_o           = '0;
    ctrl_rd_o[CB_START] = busy_q;
    ctrl_rd_o[CB_GIE]   = gie_q;
    ctrl_rd_o[CB_SRST]  = !sr_idle;
    ien_rd_o            = '0;
    ien_rd_o[SRC_W-1:0] = ien_q;
    ist_rd_o            = '0;
    ist_rd_o[SB_OVER]   = st_over;
    ist_rd_o[SB_ERR]    = st_err;
    ist_rd_o[SB_LBSY]   = st_lb;
    ist_rd_o[SB_DERR_LO +: DERR_W] = st_derr;
    ist_rd_o[SB_ACK]    = st_ack;
  end

  // R7
  abort_ends_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && abort_req && sr_idle |=> !busy_q && abort_q && st_err && !st_ack && st_derr == '0);
  // R6
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && we_cmd && sr_idle |=> st_lb);
  // R5
  ack_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_ack |-> st_err);
  // R3
  go_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !eng_done && !abort_req && !sr_req && sr_idle |=> busy_q);
  // R12
  srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_idle |=> !busy_q && !gie_q && !st_over && !st_err && ien_q == '0);
  // R13
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && eng_done && !we_ctrl && !we_ist |=> $stable(st_over) && $stable(st_err));
endmodule

// File: rtl/twb_cfg_regs.sv
module twb_cfg_regs
  import twb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DIV_W = 8,
  parameter int DLY_W = 3,
  parameter int RA_W  = 8,
  parameter int HW_W  = 16,
  parameter int RT_W  = 8,
  parameter int CMD_W = 8,
  parameter int DM_W  = 8,
  parameter int LN_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  twb_wsel_t        wsel,
  input  logic             cmd_load,
  input  logic [DW-1:0]    wd,
  input  logic             rd_load,
  input  logic [DW-1:0]    rd_data,
  input  logic             dm_done,
  input  logic             sda_in,
  input  logic             scl_in,
  output logic [DIV_W-1:0] div_o,
  output logic [DLY_W-1:0] dly_o,
  output logic [RA_W-1:0]  radr_o,
  output logic [DW-1:0]    dat_o,
  output logic [HW_W-1:0]  hw_o,
  output logic [RT_W-1:0]  rt_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [LN_W-1:0]  line_o,
  output logic             dm_go_o,
  output logic [DM_W-1:0]  dm_data_o,
  output logic [DM_W-1:0]  dm_reg_o,
  output logic [DM_W-1:0]  dm_dev_o,
  output logic [DW-1:0]    clk_rd_o,
  output logic [DW-1:0]    dev_rd_o,
  output logic [DW-1:0]    line_rd_o,
  output logic [DW-1:0]    dm_rd_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      div_o <= '0; dly_o <= '0; radr_o <= '0; dat_o <= '0; hw_o <= '0;
      rt_o <= '0; cmd_o <= '0; line_o <= '0; dm_go_o <= 1'b0;
      dm_data_o <= '0; dm_reg_o <= '0; dm_dev_o <= '0;
    end else begin
      if (wsel.clk) begin
        div_o <= wd[DIV_W-1:0];
        dly_o <= wd[CK_DLY_LO +: DLY_W];
      end
      if (wsel.adr)  radr_o <= wd[RA_W-1:0];
      if (rd_load)       dat_o <= rd_data;
      else if (wsel.dat) dat_o <= wd;
      if (wsel.dev) begin
        hw_o <= wd[HW_W-1:0];
        rt_o <= wd[DEV_RT_LO +: RT_W];
      end
      if (cmd_load)  cmd_o  <= wd[CMD_W-1:0];
      if (wsel.line) line_o <= wd[LN_W-1:0];
      if (wsel.dmode && !dm_go_o) begin
        dm_go_o   <= wd[DM_GO];
        dm_data_o <= wd[DM_DATA_LO +: DM_W];
        dm_reg_o  <= wd[DM_REG_LO +: DM_W];
        dm_dev_o  <= wd[DM_W-1:0];
      end else if (dm_done) begin
        dm_go_o <= 1'b0;
      end
    end
  end

  always_comb begin
    clk_rd_o = '0;
    clk_rd_o[DIV_W-1:0] = div_o;
    clk_rd_o[CK_DLY_LO +: DLY_W] = dly_o;
    dev_rd_o = '0;
    dev_rd_o[HW_W-1:0] = hw_o;
    dev_rd_o[DEV_RT_LO +: RT_W] = rt_o;
    line_rd_o = '0;
    line_rd_o[LN_W-1:0] = line_o;
    line_rd_o[LN_SDA_IN] = sda_in;
    line_rd_o[LN_SCL_IN] = scl_in;
    dm_rd_o = '0;
    dm_rd_o[DM_GO] = dm_go_o;
    dm_rd_o[DM_DATA_LO +: DM_W] = dm_data_o;
    dm_rd_o[DM_REG_LO +: DM_W] = dm_reg_o;
    dm_rd_o[DM_W-1:0] = dm_dev_o;
  end

  // R11
  dm_go_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_go_o && !dm_done && !clr |=> dm_go_o);
  // R11
  dm_fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_go_o && !clr |=> $stable(dm_data_o) && $stable(dm_dev_o));
  // R12
  clr_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> div_o == '0 && cmd_o == '0 && dat_o == '0 && line_o == '0 && !dm_go_o);
  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_load && !clr |=> $stable(cmd_o));
endmodule

// File: rtl/twb_regif.sv
module twb_regif
  import twb_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SRST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              eng_go,
  output logic              eng_abort,
  output logic [7:0]        eng_cmd,
  output logic [7:0]        eng_reg_addr,
  output logic [31:0]       eng_wdata,
  output logic [15:0]       eng_hw_addr,
  output logic [7:0]        eng_rt_addr,
  output logic [7:0]        eng_clk_div,
  output logic [2:0]        eng_sda_dly,
  input  logic              eng_done,
  input  logic              eng_ack_err,
  input  logic [3:0]        eng_data_err,
  input  logic              eng_rd_vld,
  input  logic [31:0]       eng_rdata,
  output logic              line_sda_oe,
  output logic              line_sda_val,
  output logic              line_scl_oe,
  output logic              line_scl_val,
  input  logic              line_sda_in,
  input  logic              line_scl_in,
  output logic              dm_go,
  output logic [7:0]        dm_data,
  output logic [7:0]        dm_reg,
  output logic [7:0]        dm_dev,
  input  logic              dm_done
);
  localparam int DW = 32;

  logic      srst_act, wr_ok, done_acc, cmd_load;
  twb_wsel_t wsel;
  logic [3:0] line_q;
  logic [DW-1:0] ctrl_rd, ien_rd, ist_rd, clk_rd, dev_rd, line_rd, dm_rd;

  assign wr_ok = bus_we && !srst_act;

  always_comb begin
    wsel       = '0;
    wsel.ctrl  = wr_ok && (bus_addr == ADDR_W'(OFS_CTRL));
    wsel.clk   = wr_ok && (bus_addr == ADDR_W'(OFS_CLK));
    wsel.ien   = wr_ok && (bus_addr == ADDR_W'(OFS_IEN));
    wsel.ist   = wr_ok && (bus_addr == ADDR_W'(OFS_IST));
    wsel.adr   = wr_ok && (bus_addr == ADDR_W'(OFS_ADR));
    wsel.dat   = wr_ok && (bus_addr == ADDR_W'(OFS_DAT));
    wsel.line  = wr_ok && (bus_addr == ADDR_W'(OFS_LINE));
    wsel.dmode = wr_ok && (bus_addr == ADDR_W'(OFS_DMODE));
    wsel.cmd   = wr_ok && (bus_addr == ADDR_W'(OFS_CMD));
    wsel.dev   = wr_ok && (bus_addr == ADDR_W'(OFS_DEV));
  end

  twb_xfer_ctrl #(.SRST_CYC(SRST_CYC), .DERR_W(4), .SRC_W(3)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .we_ctrl(wsel.ctrl), .we_ien(wsel.ien), .we_ist(wsel.ist), .we_cmd(wsel.cmd),
    .wd(bus_wdata[7:0]),
    .eng_done(eng_done), .eng_ack_err(eng_ack_err), .eng_data_err(eng_data_err),
    .busy_o(eng_go), .abort_o(eng_abort), .srst_o(srst_act),
    .done_acc_o(done_acc), .cmd_load_o(cmd_load), .irq_o(irq),
    .ctrl_rd_o(ctrl_rd), .ien_rd_o(ien_rd), .ist_rd_o(ist_rd)
  );

  twb_cfg_regs #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clr(srst_act), .wsel(wsel), .cmd_load(cmd_load),
    .wd(bus_wdata), .rd_load(done_acc && eng_rd_vld), .rd_data(eng_rdata),
    .dm_done(dm_done), .sda_in(line_sda_in), .scl_in(line_scl_in),
    .div_o(eng_clk_div), .dly_o(eng_sda_dly), .radr_o(eng_reg_addr),
    .dat_o(eng_wdata), .hw_o(eng_hw_addr), .rt_o(eng_rt_addr), .cmd_o(eng_cmd),
    .line_o(line_q), .dm_go_o(dm_go), .dm_data_o(dm_data), .dm_reg_o(dm_reg),
    .dm_dev_o(dm_dev), .clk_rd_o(clk_rd), .dev_rd_o(dev_rd),
    .line_rd_o(line_rd), .dm_rd_o(dm_rd)
  );

  assign line_sda_oe  = line_q[0];
  assign line_sda_val = line_q[1];
  assign line_scl_oe  = line_q[2];
  assign line_scl_val = line_q[3];

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == ADDR_W'(OFS_CTRL))  bus_rdata = ctrl_rd;
    else if (bus_addr == ADDR_W'(OFS_CLK))   bus_rdata = clk_rd;
    else if (bus_addr == ADDR_W'(OFS_IEN))   bus_rdata = ien_rd;
    else if (bus_addr == ADDR_W'(OFS_IST))   bus_rdata = ist_rd;
    else if (bus_addr == ADDR_W'(OFS_ADR))   bus_rdata = DW'(eng_reg_addr);
    else if (bus_addr == ADDR_W'(OFS_DAT))   bus_rdata = eng_wdata;
    else if (bus_addr == ADDR_W'(OFS_LINE))  bus_rdata = line_rd;
    else if (bus_addr == ADDR_W'(OFS_DMODE)) bus_rdata = dm_rd;
    else if (bus_addr == ADDR_W'(OFS_CMD))   bus_rdata = DW'(eng_cmd);
    else if (bus_addr == ADDR_W'(OFS_DEV))   bus_rdata = dev_rd;
  end

  // R12
  srst_blocks_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_act |=> !eng_go && !dm_go);
  // R7
  abort_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |=> !eng_abort && !eng_go);
endmodule

// File: tb/tb_twb_regif.sv
module tb_twb_regif;
  localparam int SRST = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, eng_go, eng_abort;
  logic [7:0] eng_cmd, eng_reg_addr, eng_rt_addr, eng_clk_div;
  logic [31:0] eng_wdata;
  logic [15:0] eng_hw_addr;
  logic [2:0] eng_sda_dly;
  logic eng_done = 0, eng_ack_err = 0, eng_rd_vld = 0;
  logic [3:0] eng_data_err = 0;
  logic [31:0] eng_rdata = 0;
  logic line_sda_oe, line_sda_val, line_scl_oe, line_scl_val;
  logic line_sda_in = 1, line_scl_in = 1;
  logic dm_go, dm_done = 0;
  logic [7:0] dm_data, dm_reg, dm_dev;
  int total = 0, fails = 0;
  logic [31:0] r;

  always #4 clk = ~clk;

  twb_regif #(.ADDR_W(8), .SRST_CYC(SRST)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic done_pulse(input logic ack, input logic [3:0] de, input logic rv, input logic [31:0] rdat);
    eng_done = 1; eng_ack_err = ack; eng_data_err = de; eng_rd_vld = rv; eng_rdata = rdat;
    @(posedge clk); @(negedge clk);
    eng_done = 0; eng_ack_err = 0; eng_data_err = 0; eng_rd_vld = 0;
  endtask

  initial begin
    #(8 * 200000);
    total++; fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    foreach (r[i]) ;
    rd(8'h00, r); chk("R1 ctrl", r, 0);
    rd(8'h04, r); chk("R1 clk", r, 0);
    rd(8'h08, r); chk("R1 ien", r, 0);
    rd(8'h0C, r); chk("R1 ist", r, 0);
    rd(8'h10, r); chk("R1 adr", r, 0);
    rd(8'h1C, r); chk("R1 dat", r, 0);
    rd(8'h24, r); chk("R1 line", r, 32'h30);
    rd(8'h28, r); chk("R1 dmode", r, 0);
    rd(8'h2C, r); chk("R1 cmd", r, 0);
    rd(8'h30, r); chk("R1 dev", r, 0);
    chk("R1 outs", {irq, eng_go, eng_abort, dm_go}, 0);

    // R2 clock register sweep
    for (int i = 0; i < 256; i += 17) begin
      wr(8'h04, 32'hFFFF_F800 | ((i % 8) << 8) | i);
      rd(8'h04, r); chk("R2 clk", r, ((i % 8) << 8) | i);
      chk("R2 clk out", {eng_sda_dly, eng_clk_div}, ((i % 8) << 8) | i);
    end
    wr(8'h30, 32'hAB12_3456); rd(8'h30, r); chk("R2 dev", r, 32'h0012_3456);
    chk("R2 dev out", {eng_rt_addr, eng_hw_addr}, 32'h12_3456);
    wr(8'h10, 32'hFFFF_FF5A); rd(8'h10, r); chk("R2 adr", r, 32'h5A);
    wr(8'h1C, 32'hCAFE_F00D); rd(8'h1C, r); chk("R2 dat", r, 32'hCAFE_F00D);
    wr(8'h2C, 32'h0000_0111); rd(8'h2C, r); chk("R2 cmd", r, 32'h11);

    // R3 / R4 read transfer
    wr(8'h00, 32'h82);
    rd(8'h00, r); chk("R3 ctrl busy", r, 32'h82); chk("R3 go", eng_go, 1);
    done_pulse(0, 0, 1, 32'hDEAD_BEEF);
    chk("R4 go low", eng_go, 0);
    rd(8'h0C, r); chk("R4 over", r, 32'h1);
    rd(8'h1C, r); chk("R4 rdata", r, 32'hDEAD_BEEF);
    wr(8'h0C, 32'h7);

    // R5 / R8 sweep of every error combination
    for (int a = 0; a < 2; a++)
      for (int d = 0; d < 16; d++) begin
        wr(8'h00, 32'h80);
        done_pulse(a[0], d[3:0], 0, 0);
        rd(8'h0C, r);
        if (a == 0 && d == 0) chk("R4 clean", r, 32'h1);
        else chk("R5 err", r, (a << 16) | (d << 8) | 32'h2);
        wr(8'h0C, 32'h7); rd(8'h0C, r); chk("R8 clear all", r, 0);
      end

    // R6 load-busy
    wr(8'h00, 32'h80);
    wr(8'h2C, 32'h55);
    rd(8'h2C, r); chk("R6 cmd kept", r, 32'h11);
    rd(8'h0C, r); chk("R6 lb", r, 32'h4);
    done_pulse(1, 0, 0, 0);
    wr(8'h00, 32'h80);
    wr(8'h00, 32'h80);
    done_pulse(0, 0, 0, 0);
    rd(8'h0C, r); chk("R6 all bits", r, 32'h1_0007);

    // R9 irq sweep
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 8; e++) begin
        wr(8'h08, e);
        wr(8'h00, g << 1);
        chk("R9 irq", irq, (g == 1 && e != 0));
      end

    // R8 write-1-clear steps
    wr(8'h0C, 0);  rd(8'h0C, r); chk("R8 zero", r, 32'h1_0007);
    wr(8'h0C, 1);  rd(8'h0C, r); chk("R8 over", r, 32'h1_0006);
    wr(8'h08, 1); wr(8'h00, 2); chk("R9 masked", irq, 0);
    wr(8'h0C, 4);  rd(8'h0C, r); chk("R8 lb", r, 32'h1_0002);
    wr(8'h0C, 2);  rd(8'h0C, r); chk("R8 err", r, 0);

    // R7 abort
    wr(8'h00, 32'h80);
    wr(8'h00, 32'h40);
    chk("R7 abort pulse", eng_abort, 1); chk("R7 go", eng_go, 0);
    rd(8'h00, r); chk("R7 ctrl", r, 0);
    rd(8'h0C, r); chk("R7 ist", r, 32'h2);
    @(negedge clk); chk("R7 pulse ends", eng_abort, 0);
    wr(8'h0C, 7);

    // R13 done while idle
    wr(8'h1C, 32'h1234_5678);
    done_pulse(1, 4'hF, 1, 32'hFFFF_FFFF);
    rd(8'h0C, r); chk("R13 ist", r, 0);
    rd(8'h1C, r); chk("R13 dat", r, 32'h1234_5678);

    // R10 line control sweep
    for (int v = 0; v < 16; v++)
      for (int p = 0; p < 4; p++) begin
        line_sda_in = p[0]; line_scl_in = p[1];
        wr(8'h24, 32'hFFFF_FFC0 | ((3 - p) << 4) | v);
        rd(8'h24, r); chk("R10 read", r, (p << 4) | v);
        chk("R10 pins", {line_scl_val, line_scl_oe, line_sda_val, line_sda_oe}, v);
      end

    // R11 device mode
    wr(8'h28, 32'h807C_3E00);
    chk("R11 go", dm_go, 1);
    rd(8'h28, r); chk("R11 read", r, 32'h807C_3E00);
    chk("R11 fields", {dm_data, dm_reg, dm_dev}, 32'h7C_3E00);
    wr(8'h28, 32'h0011_2233);
    rd(8'h28, r); chk("R11 ignored", r, 32'h807C_3E00);
    dm_done = 1; @(posedge clk); @(negedge clk); dm_done = 0;
    rd(8'h28, r); chk("R11 done", r, 32'h007C_3E00);
    chk("R11 go low", dm_go, 0);

    // R12 soft reset
    wr(8'h04, 32'h5A5); wr(8'h08, 7); wr(8'h00, 32'h82);
    wr(8'h00, 32'h01);
    rd(8'h00, r); chk("R12 bit0 c1", r, 1);
    wr(8'h04, 32'h77);
    rd(8'h00, r); chk("R12 bit0 c2", r, 1);
    @(negedge clk);
    rd(8'h00, r); chk("R12 bit0 c3", r, 1);
    @(negedge clk);
    rd(8'h00, r); chk("R12 bit0 end", r, 0);
    rd(8'h04, r); chk("R12 clk", r, 0);
    rd(8'h08, r); chk("R12 ien", r, 0);
    rd(8'h1C, r); chk("R12 dat", r, 0);
    rd(8'h10, r); chk("R12 adr", r, 0);
    rd(8'h28, r); chk("R12 dmode", r, 0);
    chk("R12 go", eng_go, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule